// File: doc/BRIEF.md
# Bit-Serial Sample Negator with Saturation

This block inverts the polarity of a serial stream of signed audio samples. Samples arrive least significant bit first, one bit per enabled clock, and a start strobe marks the first bit of each word. Every incoming bit is complemented and passed through a one-bit serial adder. The adder's carry is forced to one at the first bit only, so the result is the two's-complement negation built up one bit at a time.

The partial result collects in a word-wide register. Only the full word shows whether the input was the most negative code, whose negation does not fit in the word. When a word completes, its result moves to a second register, which is then shifted out most significant bit first to a converter that expects that order. If the input was the most negative code, the largest positive code is loaded in place of the computed result. Because there are two registers, one word is emitted while the next is received. An output strobe flags the first emitted bit of every word.

Top module: `serialNegator`

## Requirements
- R1: A bit on `sIn` is taken only in a cycle with `bitEn` high. `wordStart` high together with `bitEn` marks bit 0 (LSB) of a new word, and the next W-1 enabled bits are bits 1 to W-1 (bit W-1 is the sign). Enabled bits that arrive while no word is open are ignored.
- R2: For every input word x other than the most negative code, the emitted word equals (2^W - x) mod 2^W, the two's-complement negation.
- R3: The carry starts at one for every word. A word whose negation carries out of the top bit (such as 0) has no effect on the result of the word that follows it.
- R4: An input equal to the most negative code (0x8000 for W=16) produces the largest positive code (0x7FFF). The most negative code never appears as a result.
- R5: After the enabled cycle that carries input bit W-1, `sOut` shows result bit W-1. Each later enabled cycle shows the next lower bit. After bit 0 has been shown, further enables without a new completed word present 0.
- R6: `wordValid` goes high after the enabled cycle that carries bit W-1 of a word. It stays high only until the next enabled cycle, and is low after every other enabled cycle.
- R7: Words sent back to back without gaps come out back to back, with a latency of exactly one word. Output word N is emitted while input word N+1 is received.
- R8: A `wordStart` before a word is complete discards the partial word: no output is produced for it, and the new word is negated correctly.
- R9: After reset, `sOut` and `wordValid` are 0 until the first word has been completely received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Bit enable: one serial bit moves in and out per enabled cycle |
| sIn | input | 1 | Serial input data, LSB first |
| wordStart | input | 1 | Marks the LSB of an input word (qualified by bitEn) |
| sOut | output | 1 | Serial negated data, MSB first |
| wordValid | output | 1 | High while the MSB of an emitted word is on sOut |

## Verification
The hardest situations to reach from the ports are a carry that runs the full width of a word followed straight away by another word, and a word restarted partway through. The first shows whether the carry leaks from one word into the next. The second shows whether discarded bits leave a trace. The stimulus is a random stream with a fixed seed. It contains directed runs in which 0 is followed by small values and the most negative code is followed by its neighbours, and truncated words in which the start strobe comes again early. Random gaps in the bit enable check that the output moves only on enabled cycles.

// File: rtl/negPkg.sv
package negPkg;

  // strobes from the sequencing logic to the arithmetic path
  typedef struct packed {
    logic shift;   // an input bit belonging to an open word is present
    logic first;   // this bit is the LSB of a new word
    logic last;    // this bit is the sign bit, the word completes
  } negStrobesT;

endpackage

// File: rtl/negCtl.sv
module negCtl
  import negPkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       wordStart,
  output negStrobesT strb,
  output logic       wordValid
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LASTIDX = CW'(W - 1);

  logic          inWord;
  logic [CW-1:0] bitCnt;
  logic [CW-1:0] idx;
  logic          active;

  always_comb begin
    active     = bitEn & (wordStart | inWord);
    idx        = wordStart ? '0 : bitCnt;
    strb.shift = active;
    strb.first = bitEn & wordStart;
    strb.last  = active & (idx == LASTIDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWord <= 1'b0;
      bitCnt <= '0;
    end else if (active) begin
      if (strb.last) begin
        inWord <= 1'b0;
        bitCnt <= '0;
      end else begin
        inWord <= 1'b1;
        bitCnt <= idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          wordValid <= 1'b0;
    else if (strb.last) wordValid <= 1'b1;
    else if (bitEn)     wordValid <= 1'b0;
  end

  // R6: a completed word raises the output strobe
  assert_valid_follows_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> wordValid);

  // R6: the strobe lasts for a single enabled cycle
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && bitEn && !strb.last) |=> !wordValid);

  // R1: a word start and a word end never share a bit when W > 1
  assert_first_last_apart_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.first, strb.last}));

endmodule

// File: rtl/negDp.sv
module negDp
  import negPkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       sIn,
  input  negStrobesT strb,
  output logic       sOut
);

  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

  logic         carryQ;
  logic         lowZeroQ;
  logic [W-1:0] accQ;
  logic [W-1:0] outQ;
  logic         loadedQ;

  logic         invBit;
  logic         carryIn;
  logic         sumBit;
  logic [W-1:0] fullSum;
  logic         mostNeg;

  always_comb begin
    invBit  = ~sIn;
    carryIn = strb.first ? 1'b1 : carryQ;
    sumBit  = invBit ^ carryIn;
    fullSum = {sumBit, accQ[W-1:1]};
    // every bit below the sign was zero and the sign is one
    mostNeg = lowZeroQ & sIn;
  end

  // serial adder and input collection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ   <= 1'b0;
      lowZeroQ <= 1'b0;
      accQ     <= '0;
    end else if (strb.shift) begin
      carryQ   <= invBit & carryIn;
      lowZeroQ <= (strb.first ? 1'b1 : lowZeroQ) & ~sIn;
      accQ     <= fullSum;
    end
  end

  // held output word, shifted MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ    <= '0;
      loadedQ <= 1'b0;
    end else if (strb.last) begin
      outQ    <= mostNeg ? MAXPOS : fullSum;
      loadedQ <= 1'b1;
    end else if (bitEn) begin
      outQ    <= {outQ[W-2:0], 1'b0};
    end
  end

  assign sOut = outQ[W-1];

  // R4: the unrepresentable result never reaches the output register
  assert_no_min_result_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> outQ != MINNEG);

  // R5: between loads the word moves one place per enable
  assert_msb_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !strb.last) |=> sOut == $past(outQ[W-2]));

  // R9: no output activity before the first complete word
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !loadedQ |-> outQ == '0);

  // R3: carry is consumed fresh at every word start
  assert_carry_fresh_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.first && sIn) |=> !carryQ);

endmodule

// File: rtl/serialNegator.sv
module serialNegator #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic sIn,
  input  logic wordStart,
  output logic sOut,
  output logic wordValid
);

  negPkg::negStrobesT strb;

  negCtl #(.W(W)) i_negCtl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .wordStart (wordStart),
    .strb      (strb),
    .wordValid (wordValid)
  );

  negDp #(.W(W)) i_negDp (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (bitEn),
    .sIn   (sIn),
    .strb  (strb),
    .sOut  (sOut)
  );

endmodule

// File: tb/test_serialNegator.sv
`timescale 1ns/1ps
module test_serialNegator;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic sIn = 1'b0;
  logic wordStart = 1'b0;
  logic sOut;
  logic wordValid;

  logic lastMark = 1'b0;   // bench-side marker: current bit is a sign bit
  int   checks = 0;
  int   fails = 0;
  bit   anyDone = 1'b0;
  bit   finished = 1'b0;

  logic [W-1:0] expQ[$];
  logic [W-1:0] shiftWord;
  int           collect = 0;

  always #2.5 clk = ~clk;

  serialNegator #(.W(W)) i_serialNegator (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .sIn(sIn),
    .wordStart(wordStart), .sOut(sOut), .wordValid(wordValid)
  );

  function automatic logic [W-1:0] negSat(input logic [W-1:0] x);
    if (x == {1'b1, {(W-1){1'b0}}}) return {1'b0, {(W-1){1'b1}}};
    return (~x) + 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one observation per enabled cycle, 1 ns after the edge
  always @(posedge clk) begin
    automatic bit enWas = bitEn;
    automatic bit lastWas = lastMark;
    #1;
    if (rstN && enWas) begin
      check(wordValid == lastWas, "R6/R7", W'(wordValid), W'(lastWas));
      if (!anyDone && !lastWas)
        check(sOut == 1'b0, "R9", W'(sOut), '0);
      if (lastWas) anyDone = 1'b1;
      if (wordValid) begin
        if (collect != 0) check(1'b0, "R7", W'(collect), '0);
        collect = W;
        shiftWord = '0;
      end
      if (collect > 0) begin
        shiftWord = {shiftWord[W-2:0], sOut};
        collect--;
        if (collect == 0) begin
          if (expQ.size() == 0) check(1'b0, "R8", shiftWord, '0);
          else begin
            automatic logic [W-1:0] e = expQ.pop_front();
            check(shiftWord == e, "R2/R3/R4/R5", shiftWord, e);
          end
        end
      end else if (anyDone && !wordValid) begin
        check(sOut == 1'b0, "R5", W'(sOut), '0);
      end
    end
  end

  task automatic sendBit(input logic b, input logic st, input logic lst, input int gap);
    @(negedge clk);
    sIn = b; wordStart = st; bitEn = 1'b1; lastMark = lst;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bitEn = 1'b0; lastMark = 1'b0; wordStart = 1'b0; sIn = $urandom_range(1);
    end
  endtask

  task automatic sendWord(input logic [W-1:0] x, input int maxGap);
    for (int i = 0; i < W; i++)
      sendBit(x[i], i == 0, i == W - 1, (maxGap > 0) ? $urandom_range(maxGap) : 0);
    expQ.push_back(negSat(x));
  endtask

  task automatic sendPartial(input logic [W-1:0] x, input int n);
    for (int i = 0; i < n; i++) sendBit(x[i], i == 0, 1'b0, 0);
  endtask

  initial begin
    automatic logic [W-1:0] dir[8] = '{16'h0000, 16'h0001, 16'h8000, 16'h0000,
                                       16'h8001, 16'h7FFF, 16'hFFFF, 16'h8000};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(sOut == 1'b0 && wordValid == 1'b0, "R9", W'({sOut, wordValid}), '0);
    rstN = 1'b1;
    // R1 / R9: stray bits with no word open
    for (int i = 0; i < 20; i++) sendBit($urandom_range(1), 1'b0, 1'b0, 0);
    // directed back-to-back corners (R3, R4, R7)
    foreach (dir[k]) sendWord(dir[k], 0);
    // R8: aborted words followed by full ones
    sendPartial(16'hA5A5, 7);
    sendWord(16'h1234, 0);
    sendPartial(16'h8000, W - 1);
    sendWord(16'h8000, 0);
    // random stream with gaps in the enable
    for (int n = 0; n < 300; n++) begin
      automatic logic [W-1:0] v = $urandom();
      if (n % 17 == 0) v = 16'h8000;
      sendWord(v, (n % 3 == 0) ? 2 : 0);
    end
    // flush the last word and check trailing zeros (R5)
    for (int i = 0; i < 2 * W; i++) sendBit(1'b1, 1'b0, 1'b0, 0);
    @(negedge clk); bitEn = 1'b0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7", W'(expQ.size()), '0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule